// File: doc/BRIEF.md
# Chained Transfer Completion Controller

This block runs one activation of an interrupt-driven data mover and then settles what happens after the move. A peripheral request carries a source index and the address of a register-information set held in memory. The set is four consecutive words: a mode word, a source address, a destination address and a transfer count. The controller reads the set, copies one byte or one 16-bit word from the source address to the destination address, and writes the updated count back into the set.

The mode word controls what happens next. If its chain bit is set, the controller goes straight on to the next set, four addresses further on, and serves it under the same request. If the chain bit is clear, it decides whether to clear the activating interrupt flag, whether to clear the per-source enable bit and whether the CPU sees an interrupt. It then returns to waiting. A word transfer from an odd source address is refused and reported as an address error.

The states are IDLE, READ_INFO, READ_DATA, WRITE_DATA, WRITE_BACK_INFO and END. The transitions are:
- IDLE to READ_INFO when a request arrives.
- READ_INFO to READ_DATA once the four words have been captured.
- READ_DATA to WRITE_DATA for an aligned access.
- READ_DATA to END for a misaligned access.
- WRITE_DATA to WRITE_BACK_INFO.
- WRITE_BACK_INFO to READ_INFO when the chain bit is set.
- WRITE_BACK_INFO to END when the chain bit is clear.
- END to IDLE.

Top module: `xfer_chain_ctl`

## Requirements
- R1: With the chain bit (mode bit 7) clear, the controller performs exactly one data move, passes through END with its completion pulses and no bus request, and then returns to idle (`busy` low).
- R2: With the chain bit set, the controller reads the next set at info base + 4 and performs that set's move under the same request.
- R3: For a set whose chain bit is set, the count is written back unchanged, and neither `flag_clr`, `en_clr` nor `cpu_irq` is pulsed for that set.
- R4: With the interrupt-select bit (mode bit 6) clear and a count that is still non-zero after decrement, `flag_clr` pulses once and `cpu_irq` stays low.
- R5: When the decremented count of a non-chained set reaches 0, `en_clr` and `cpu_irq` pulse and `flag_clr` stays low.
- R6: With the interrupt-select bit set, `cpu_irq` pulses after every non-chained transfer and `flag_clr` never pulses.
- R7: Mode bit 8 selects the size: 1 moves the low 16 bits and 0 moves the low 8 bits. Both sizes are written zero-extended.
- R8: A word transfer whose source address has bit 0 set pulses `addr_err` only. No data is written, no count is written back, and `cpu_irq`, `flag_clr` and `en_clr` all stay low.
- R9: Mode bits 5 to 0 have no effect on behaviour.
- R10: A request that arrives while `busy` is high is ignored.
- R11: After reset the block is idle, and all of its bus and completion outputs are low.
- R12: A non-chained set has its count decremented by one and written to info base + 3. `done_src` carries the activating source index during the completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req | input | 1 | Activation request, one cycle |
| act_src | input | SRC_W | Index of the activating source |
| act_info_base | input | ADDR_W | Address of the first register-information set |
| busy | output | 1 | High whenever the controller is not idle |
| mem_req | output | 1 | Bus request; read data is valid in the following cycle |
| mem_we | output | 1 | Write strobe qualifying `mem_req` |
| mem_word | output | 1 | High for a 16-bit data access |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after the request |
| done_src | output | SRC_W | Source index that goes with the completion pulses |
| flag_clr | output | 1 | Pulse: clear the activating interrupt flag |
| en_clr | output | 1 | Pulse: clear the per-source transfer enable |
| cpu_irq | output | 1 | Pulse: let the CPU interrupt through |
| addr_err | output | 1 | Pulse: word transfer from an odd address refused |

## Verification
The bench uses the default parameters: a 24-bit address, a 32-bit data bus, a 16-bit count and a 4-bit source index. Small counts of 1, 3 and 5 reach the count-reaches-zero boundary and the still-non-zero case in a single activation each. The bench memory decodes the low 8 address bits, which is enough room for two chained sets, several source and destination cells, and an odd source address for the misalignment case.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_INFO,
        S_READ_DATA,
        S_WRITE_DATA,
        S_WRITE_BACK_INFO,
        S_END
    } ctc_state_e;

    localparam int MODE_CHAIN_BIT = 7;
    localparam int MODE_ISEL_BIT  = 6;
    localparam int MODE_SIZE_BIT  = 8;

    localparam int INFO_MODE  = 0;
    localparam int INFO_SRC   = 1;
    localparam int INFO_DST   = 2;
    localparam int INFO_CNT   = 3;
    localparam int INFO_WORDS = 4;

    typedef struct packed {
        logic word;
        logic chain;
        logic isel;
    } ctc_mode_t;

    function automatic ctc_mode_t decode_mode(input logic [8:0] w);
        ctc_mode_t m;
        m.word  = w[MODE_SIZE_BIT];
        m.chain = w[MODE_CHAIN_BIT];
        m.isel  = w[MODE_ISEL_BIT];
        return m;
    endfunction

endpackage

// File: rtl/ctc_info_regs.sv
module ctc_info_regs
    import ctc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [1:0]        cap_idx,
    input  logic [DATA_W-1:0] rdata,
    output ctc_mode_t         mode,
    output logic [ADDR_W-1:0] sar,
    output logic [ADDR_W-1:0] dar,
    output logic [CNT_W-1:0]  count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= '0;
            sar   <= '0;
            dar   <= '0;
            count <= '0;
        end else if (cap_en) begin
            unique case (cap_idx)
                2'(INFO_MODE): mode  <= decode_mode(rdata[8:0]);
                2'(INFO_SRC):  sar   <= rdata[ADDR_W-1:0];
                2'(INFO_DST):  dar   <= rdata[ADDR_W-1:0];
                2'(INFO_CNT):  count <= rdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctc_decide.sv
module ctc_decide
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  ctc_mode_t        mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cnt_next,
    output logic             want_flag_clr,
    output logic             want_en_clr,
    output logic             want_irq
);

    logic reached_zero;

    always_comb begin
        cnt_next      = mode.chain ? count : count - CNT_W'(1);
        reached_zero  = !mode.chain && (cnt_next == '0);
        want_en_clr   = reached_zero;
        want_irq      = !mode.chain && (mode.isel || reached_zero);
        want_flag_clr = !mode.chain && !mode.isel && !reached_zero;
    end

endmodule

// File: rtl/ctc_data_path.sv
module ctc_data_path #(
    parameter int DATA_W = 32
) (
    input  logic              word,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wdata
);

    localparam int HALF = 16;
    localparam int BYTE = 8;

    always_comb begin
        if (word) begin
            wdata = {{(DATA_W-HALF){1'b0}}, rdata[HALF-1:0]};
        end else begin
            wdata = {{(DATA_W-BYTE){1'b0}}, rdata[BYTE-1:0]};
        end
    end

endmodule

// File: rtl/xfer_chain_ctl.sv
module xfer_chain_ctl
    import ctc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int SRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_req,
    input  logic [SRC_W-1:0]  act_src,
    input  logic [ADDR_W-1:0] act_info_base,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [SRC_W-1:0]  done_src,
    output logic              flag_clr,
    output logic              en_clr,
    output logic              cpu_irq,
    output logic              addr_err
);

    localparam int IDX_W  = 3;
    localparam int IDX_LAST = INFO_WORDS;

    ctc_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;
    logic [SRC_W-1:0]  src_q;
    logic              res_flag, res_en, res_irq, res_err;

    ctc_mode_t         mode;
    logic [ADDR_W-1:0] sar, dar;
    logic [CNT_W-1:0]  count, cnt_next;
    logic              want_flag_clr, want_en_clr, want_irq;
    logic [DATA_W-1:0] moved_data;
    logic              cap_en;
    logic [1:0]        cap_idx;
    logic              misaligned;

    assign cap_en     = (state == S_READ_INFO) && (idx != '0);
    assign cap_idx    = 2'(idx - IDX_W'(1));
    assign misaligned = mode.word && sar[0];

    ctc_info_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) info_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .cap_idx(cap_idx),
        .rdata  (mem_rdata),
        .mode   (mode),
        .sar    (sar),
        .dar    (dar),
        .count  (count)
    );

    ctc_decide #(
        .CNT_W(CNT_W)
    ) decide_i (
        .mode         (mode),
        .count        (count),
        .cnt_next     (cnt_next),
        .want_flag_clr(want_flag_clr),
        .want_en_clr  (want_en_clr),
        .want_irq     (want_irq)
    );

    ctc_data_path #(
        .DATA_W(DATA_W)
    ) data_i (
        .word (mode.word),
        .rdata(mem_rdata),
        .wdata(moved_data)
    );

    // State register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx      <= '0;
            base     <= '0;
            src_q    <= '0;
            res_flag <= 1'b0;
            res_en   <= 1'b0;
            res_irq  <= 1'b0;
            res_err  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (act_req) begin
                        src_q <= act_src;
                        base  <= act_info_base;
                        idx   <= '0;
                        state <= S_READ_INFO;
                    end
                end
                S_READ_INFO: begin
                    if (idx == IDX_W'(IDX_LAST)) begin
                        idx   <= '0;
                        state <= S_READ_DATA;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                S_READ_DATA: begin
                    if (misaligned) begin
                        res_err <= 1'b1;
                        state   <= S_END;
                    end else begin
                        state <= S_WRITE_DATA;
                    end
                end
                S_WRITE_DATA: begin
                    state <= S_WRITE_BACK_INFO;
                end
                S_WRITE_BACK_INFO: begin
                    if (mode.chain) begin
                        base  <= base + ADDR_W'(INFO_WORDS);
                        idx   <= '0;
                        state <= S_READ_INFO;
                    end else begin
                        res_flag <= want_flag_clr;
                        res_en   <= want_en_clr;
                        res_irq  <= want_irq;
                        state    <= S_END;
                    end
                end
                S_END: begin
                    res_flag <= 1'b0;
                    res_en   <= 1'b0;
                    res_irq  <= 1'b0;
                    res_err  <= 1'b0;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        flag_clr  = 1'b0;
        en_clr    = 1'b0;
        cpu_irq   = 1'b0;
        addr_err  = 1'b0;
        done_src  = src_q;
        unique case (state)
            S_IDLE: ;
            S_READ_INFO: begin
                if (idx != IDX_W'(IDX_LAST)) begin
                    mem_req  = 1'b1;
                    mem_addr = base + ADDR_W'(idx);
                end
            end
            S_READ_DATA: begin
                if (!misaligned) begin
                    mem_req  = 1'b1;
                    mem_word = mode.word;
                    mem_addr = sar;
                end
            end
            S_WRITE_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_word  = mode.word;
                mem_addr  = dar;
                mem_wdata = moved_data;
            end
            S_WRITE_BACK_INFO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base + ADDR_W'(INFO_CNT);
                mem_wdata = DATA_W'(cnt_next);
            end
            S_END: begin
                flag_clr = res_flag;
                en_clr   = res_en;
                cpu_irq  = res_irq;
                addr_err = res_err;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_word,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              flag_clr,
    input logic              en_clr,
    input logic              cpu_irq,
    input logic              addr_err
);

    logic any_done;
    assign any_done = flag_clr || en_clr || cpu_irq || addr_err;

    p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !(cpu_irq || flag_clr || en_clr));

    p_word_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_word) |-> !mem_addr[0]);

    p_flag_hides_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |-> !cpu_irq);

    p_zero_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |-> (cpu_irq && !flag_clr));

    p_back_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_done |=> !busy);

    p_quiet_bus_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_done |-> !mem_req);

    p_busy_with_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

bind xfer_chain_ctl ctc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .mem_req (mem_req),
    .mem_word(mem_word),
    .mem_addr(mem_addr),
    .flag_clr(flag_clr),
    .en_clr  (en_clr),
    .cpu_irq (cpu_irq),
    .addr_err(addr_err)
);

// File: tb/xfer_chain_ctl_tb_top.sv
`timescale 1ns/1ps
module xfer_chain_ctl_tb_top;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int SRC_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              act_req = 1'b0;
    logic [SRC_W-1:0]  act_src = '0;
    logic [ADDR_W-1:0] act_info_base = '0;
    logic              busy, mem_req, mem_we, mem_word;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [SRC_W-1:0]  done_src;
    logic              flag_clr, en_clr, cpu_irq, addr_err;

    logic [DATA_W-1:0] mem [0:255];

    int n_checks = 0;
    int n_fail   = 0;
    int n_flag, n_en, n_irq, n_err, n_writes;
    logic [SRC_W-1:0] last_src;

    always #2.5 clk = ~clk;

    xfer_chain_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SRC_W(SRC_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_src(act_src),
        .act_info_base(act_info_base), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done_src(done_src),
        .flag_clr(flag_clr), .en_clr(en_clr), .cpu_irq(cpu_irq),
        .addr_err(addr_err)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (flag_clr) n_flag++;
            if (en_clr)   n_en++;
            if (cpu_irq)  n_irq++;
            if (addr_err) n_err++;
            if (mem_req && mem_we) n_writes++;
            if (flag_clr || en_clr || cpu_irq || addr_err) last_src = done_src;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_info(input int base, input logic [31:0] mode,
                            input int sar, input int dar, input int cnt);
        mem[base]   = mode;
        mem[base+1] = 32'(sar);
        mem[base+2] = 32'(dar);
        mem[base+3] = 32'(cnt);
    endtask

    task automatic clear_counts();
        n_flag = 0; n_en = 0; n_irq = 0; n_err = 0; n_writes = 0;
        last_src = '0;
    endtask

    task automatic activate(input logic [SRC_W-1:0] s, input int base);
        clear_counts();
        @(negedge clk);
        act_req = 1'b1;
        act_src = s;
        act_info_base = ADDR_W'(base);
        @(negedge clk);
        act_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 busy", busy, 0);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 done pulses", {flag_clr, en_clr, cpu_irq, addr_err}, 0);
    endtask

    task automatic t_single_byte();
        set_info(8'h10, 32'h0000_0000, 8'h40, 8'h50, 3);
        mem[8'h40] = 32'hDEAD_BEEF;
        mem[8'h50] = 32'hFFFF_FFFF;
        activate(4'd5, 8'h10);
        chk("R10 busy after request", busy, 1);
        wait_idle();
        chk("R1 idle again", busy, 0);
        chk("R1 writes", n_writes, 2);
        chk("R7 byte moved", mem[8'h50], 32'h0000_00EF);
        chk("R12 count decremented", mem[8'h13], 2);
        chk("R4 flag cleared", n_flag, 1);
        chk("R4 no irq", n_irq, 0);
        chk("R4 no enable clear", n_en, 0);
        chk("R12 done_src", last_src, 5);
    endtask

    task automatic t_count_zero_word();
        set_info(8'h20, 32'h0000_0100, 8'h42, 8'h52, 1);
        mem[8'h42] = 32'h1234_BEEF;
        mem[8'h52] = 32'hFFFF_FFFF;
        activate(4'd3, 8'h20);
        wait_idle();
        chk("R7 word moved", mem[8'h52], 32'h0000_BEEF);
        chk("R5 count zero", mem[8'h23], 0);
        chk("R5 irq", n_irq, 1);
        chk("R5 enable cleared", n_en, 1);
        chk("R5 flag kept", n_flag, 0);
    endtask

    task automatic t_isel();
        set_info(8'h30, 32'h0000_0040, 8'h44, 8'h54, 5);
        mem[8'h44] = 32'h0000_0077;
        activate(4'd9, 8'h30);
        wait_idle();
        chk("R6 irq every transfer", n_irq, 1);
        chk("R6 flag never cleared", n_flag, 0);
        chk("R6 count", mem[8'h33], 4);
        chk("R6 data", mem[8'h54], 32'h77);
    endtask

    task automatic t_chain();
        set_info(8'h60, 32'h0000_0080, 8'h46, 8'h56, 7);
        set_info(8'h64, 32'h0000_0000, 8'h48, 8'h58, 2);
        mem[8'h46] = 32'h0000_00A1;
        mem[8'h48] = 32'h0000_00B2;
        mem[8'h56] = 0;
        mem[8'h58] = 0;
        activate(4'd2, 8'h60);
        wait_idle();
        chk("R2 first move", mem[8'h56], 32'hA1);
        chk("R2 second move", mem[8'h58], 32'hB2);
        chk("R3 chained count unchanged", mem[8'h63], 7);
        chk("R12 last count", mem[8'h67], 1);
        chk("R3 single flag clear", n_flag, 1);
        chk("R3 no irq", n_irq, 0);
        chk("R3 no enable clear", n_en, 0);
        chk("R2 write count", n_writes, 4);
    endtask

    task automatic t_addr_err();
        set_info(8'h70, 32'h0000_0100, 8'h41, 8'h5A, 4);
        mem[8'h41] = 32'h0000_5555;
        mem[8'h5A] = 32'hCAFE_CAFE;
        activate(4'd7, 8'h70);
        wait_idle();
        chk("R8 error", n_err, 1);
        chk("R8 no data write", mem[8'h5A], 32'hCAFE_CAFE);
        chk("R8 count kept", mem[8'h73], 4);
        chk("R8 no writes", n_writes, 0);
        chk("R8 silent", n_irq + n_flag + n_en, 0);
    endtask

    task automatic t_reserved();
        set_info(8'h80, 32'h0000_003F, 8'h4A, 8'h5C, 3);
        mem[8'h4A] = 32'h0000_1234;
        activate(4'd1, 8'h80);
        wait_idle();
        chk("R9 byte data", mem[8'h5C], 32'h34);
        chk("R9 count", mem[8'h83], 2);
        chk("R9 flag", n_flag, 1);
        chk("R9 irq", n_irq, 0);
    endtask

    task automatic t_busy_ignore();
        set_info(8'h90, 32'h0000_0000, 8'h4C, 8'h5E, 3);
        set_info(8'hA0, 32'h0000_0000, 8'h4C, 8'h5F, 3);
        mem[8'h4C] = 32'h0000_0066;
        mem[8'h5F] = 32'h1111_1111;
        activate(4'd4, 8'h90);
        @(negedge clk);
        act_req = 1'b1;
        act_src = 4'd11;
        act_info_base = ADDR_W'(8'hA0);
        @(negedge clk);
        act_req = 1'b0;
        wait_idle();
        chk("R10 first done", mem[8'h5E], 32'h66);
        chk("R10 second ignored", mem[8'h5F], 32'h1111_1111);
        chk("R10 second count kept", mem[8'hA3], 3);
        chk("R10 source", last_src, 4);
        chk("R10 flag pulses", n_flag, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        clear_counts();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_single_byte();
        t_count_zero_word();
        t_isel();
        t_chain();
        t_addr_err();
        t_reserved();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule